// File: doc/BRIEF.md
# Radix-4 Add-Only Butterfly

This block computes a four-point discrete Fourier transform on four complex samples that arrive together in one cycle. The only constants in such a transform are +1, −1, +j and −j, so the datapath has no multipliers. Each product by ±j becomes an exchange of the real and imaginary parts, and one of the two is negated. The work is done in two registered adder stages. The first stage forms sums and differences of the even-indexed pair (x0, x2) and of the odd-indexed pair (x1, x3). The second stage combines those four partial results into the four outputs.

The block is meant to sit after a one-to-four deserializer. It then runs at one quarter of the serial sample clock and accepts a new group of four samples on every cycle, with no bubbles. The real and imaginary parts go through two identical lanes. The lanes cross only in the second stage, where the ±j terms are formed. Every stage widens the word by one bit, so no input value can overflow.

Top module: `r4_butterfly`

## Requirements
- R1: While reset is asserted, and after reset until the first valid group has passed through, out_valid is 0 and every output word is 0.
- R2: out_valid equals in_valid as it was sampled two rising clock edges earlier, and the latency is exactly two cycles.
- R3: Output 0 (index 0 of the packed output arrays) is the sum of all four inputs, computed separately for the real and the imaginary parts.
- R4: Output 2 is x0 − x1 + x2 − x3, computed separately for the real and the imaginary parts.
- R5: Output 1 is (x0 − x2) − j·(x1 − x3). Its real part is (re0 − re2) + (im1 − im3) and its imaginary part is (im0 − im2) − (re1 − re3).
- R6: Output 3 is (x0 − x2) + j·(x1 − x3). Its real part is (re0 − re2) − (im1 − im3) and its imaginary part is (im0 − im2) + (re1 − re3).
- R7: Inputs are IN_W-bit two's complement and outputs are IN_W+2-bit two's complement. Results are exact for all input values, including every input at −2^(IN_W−1) or at 2^(IN_W−1)−1.
- R8: Input words presented with in_valid low are ignored. In the cycle where out_valid is low, the outputs keep the values of the last valid result.
- R9: Groups applied on consecutive cycles produce results on consecutive cycles, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at one quarter of the serial sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The four input samples are valid this cycle |
| in_re | input | 4×IN_W | Real parts; element k is sample x_k |
| in_im | input | 4×IN_W | Imaginary parts; element k is sample x_k |
| out_valid | output | 1 | The four output bins are valid |
| out_re | output | 4×(IN_W+2) | Real parts; element k is bin X_k |
| out_im | output | 4×(IN_W+2) | Imaginary parts; element k is bin X_k |

## Verification
The block holds no state other than the two pipeline registers. A wrong value in a first-stage partial shows up in the output bins on the next edge. Each partial feeds two bins, so an error always hits a pair of bins (0 and 2, or 1 and 3) together. A swapped or wrongly signed ±j term affects only bins 1 and 3, and only when the odd inputs have nonzero imaginary or real parts. The bench therefore drives odd samples that are purely real and others that are purely imaginary. An error in a load enable or in the valid pipeline shows up within two cycles: either as a result at the wrong position in the result stream, or as an output that changes during an idle cycle.

// File: rtl/r4_pkg.sv
package r4_pkg;
    localparam int POINTS = 4;
    localparam int LANES  = 2;

    typedef enum logic {
        LANE_RE = 1'b0,
        LANE_IM = 1'b1
    } lane_e;
endpackage

// File: rtl/r4_pair_stage.sv
module r4_pair_stage #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [3:0][W-1:0]   x,
    output logic [W:0]          even_sum,
    output logic [W:0]          even_dif,
    output logic [W:0]          odd_sum,
    output logic [W:0]          odd_dif
);
    logic signed [W:0] x0e, x1e, x2e, x3e;
    logic signed [W:0] es_n, ed_n, os_n, od_n;

    always_comb begin
        x0e  = {x[0][W-1], x[0]};
        x1e  = {x[1][W-1], x[1]};
        x2e  = {x[2][W-1], x[2]};
        x3e  = {x[3][W-1], x[3]};
        es_n = x0e + x2e;
        ed_n = x0e - x2e;
        os_n = x1e + x3e;
        od_n = x1e - x3e;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            even_sum <= '0;
            even_dif <= '0;
            odd_sum  <= '0;
            odd_dif  <= '0;
        end else if (en) begin
            even_sum <= es_n;
            even_dif <= ed_n;
            odd_sum  <= os_n;
            odd_dif  <= od_n;
        end
    end
endmodule

// File: rtl/r4_combine_stage.sv
module r4_combine_stage #(
    parameter int W = 17
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [W-1:0]        es_re,
    input  logic [W-1:0]        ed_re,
    input  logic [W-1:0]        os_re,
    input  logic [W-1:0]        od_re,
    input  logic [W-1:0]        es_im,
    input  logic [W-1:0]        ed_im,
    input  logic [W-1:0]        os_im,
    input  logic [W-1:0]        od_im,
    output logic [3:0][W:0]     y_re,
    output logic [3:0][W:0]     y_im
);
    logic signed [W:0] esr, edr, osr, odr, esi, edi, osi, odi;
    logic [3:0][W:0]   nre, nim;

    always_comb begin
        esr = {es_re[W-1], es_re};
        edr = {ed_re[W-1], ed_re};
        osr = {os_re[W-1], os_re};
        odr = {od_re[W-1], od_re};
        esi = {es_im[W-1], es_im};
        edi = {ed_im[W-1], ed_im};
        osi = {os_im[W-1], os_im};
        odi = {od_im[W-1], od_im};
        // bin 0 and bin 2: plain sum and difference of the pair sums
        nre[0] = esr + osr;
        nim[0] = esi + osi;
        nre[2] = esr - osr;
        nim[2] = esi - osi;
        // bin 1: even difference minus j times odd difference
        nre[1] = edr + odi;
        nim[1] = edi - odr;
        // bin 3: even difference plus j times odd difference
        nre[3] = edr - odi;
        nim[3] = edi + odr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_re <= '0;
            y_im <= '0;
        end else if (en) begin
            y_re <= nre;
            y_im <= nim;
        end
    end
endmodule

// File: rtl/r4_butterfly.sv
module r4_butterfly #(
    parameter int IN_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [3:0][IN_W-1:0]        in_re,
    input  logic [3:0][IN_W-1:0]        in_im,
    output logic                        out_valid,
    output logic [3:0][IN_W+1:0]        out_re,
    output logic [3:0][IN_W+1:0]        out_im
);
    import r4_pkg::*;

    localparam int MID_W = IN_W + 1;

    logic [LANES-1:0][3:0][IN_W-1:0] lane_in;
    logic [LANES-1:0][MID_W-1:0]     p_es, p_ed, p_os, p_od;
    logic                            mid_valid;

    assign lane_in[LANE_RE] = in_re;
    assign lane_in[LANE_IM] = in_im;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        r4_pair_stage #(.W(IN_W)) i_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (in_valid),
            .x        (lane_in[g]),
            .even_sum (p_es[g]),
            .even_dif (p_ed[g]),
            .odd_sum  (p_os[g]),
            .odd_dif  (p_od[g])
        );
    end

    r4_combine_stage #(.W(MID_W)) i_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (mid_valid),
        .es_re (p_es[LANE_RE]),
        .ed_re (p_ed[LANE_RE]),
        .os_re (p_os[LANE_RE]),
        .od_re (p_od[LANE_RE]),
        .es_im (p_es[LANE_IM]),
        .ed_im (p_ed[LANE_IM]),
        .os_im (p_os[LANE_IM]),
        .od_im (p_od[LANE_IM]),
        .y_re  (out_re),
        .y_im  (out_im)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mid_valid <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            mid_valid <= in_valid;
            out_valid <= mid_valid;
        end
    end
endmodule

// File: rtl/r4_butterfly_chk.sv
module r4_butterfly_chk #(
    parameter int IN_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [3:0][IN_W-1:0]        in_re,
    input  logic [3:0][IN_W-1:0]        in_im,
    input  logic                        out_valid,
    input  logic [3:0][IN_W+1:0]        out_re,
    input  logic [3:0][IN_W+1:0]        out_im
);
    localparam int OUT_W = IN_W + 2;

    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    function automatic logic signed [OUT_W-1:0] ext(input logic [IN_W-1:0] v);
        return {{2{v[IN_W-1]}}, v};
    endfunction

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && out_re == '0 && out_im == '0));

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && !$past(in_valid, 2)) |-> ($stable(out_re) && $stable(out_im)));

    // R3
    bin0_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && out_valid) |->
        ($signed(out_re[0]) == ext($past(in_re[0], 2)) + ext($past(in_re[1], 2))
                             + ext($past(in_re[2], 2)) + ext($past(in_re[3], 2))));

    // R5
    bin1_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && out_valid) |->
        ($signed(out_re[1]) == ext($past(in_re[0], 2)) - ext($past(in_re[2], 2))
                             + ext($past(in_im[1], 2)) - ext($past(in_im[3], 2))));
endmodule

bind r4_butterfly r4_butterfly_chk #(.IN_W(IN_W)) i_chk (.*);

// File: tb/test_r4_butterfly.sv
module test_r4_butterfly;
    localparam int IN_W  = 16;
    localparam int OUT_W = IN_W + 2;

    logic                   clk;
    logic                   rst_n;
    logic                   in_valid;
    logic [3:0][IN_W-1:0]   in_re;
    logic [3:0][IN_W-1:0]   in_im;
    logic                   out_valid;
    logic [3:0][OUT_W-1:0]  out_re;
    logic [3:0][OUT_W-1:0]  out_im;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int q_cyc[$];
    int q_val[$];
    int last_val[8];
    bit have_last = 0;
    bit done      = 0;

    r4_butterfly #(.IN_W(IN_W)) i_r4_butterfly (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int got(input int k);
        if (k < 4) return int'($signed(out_re[k]));
        return int'($signed(out_im[k-4]));
    endfunction

    function automatic string tag(input int k);
        case (k % 4)
            0:       return "R3";
            1:       return "R5";
            2:       return "R4";
            default: return "R6";
        endcase
    endfunction

    // drive one group at the current negedge; push expected bins when valid
    task automatic send(input bit v, input int r[4], input int m[4]);
        int e[8];
        in_valid = v;
        for (int k = 0; k < 4; k++) begin
            in_re[k] = IN_W'(r[k]);
            in_im[k] = IN_W'(m[k]);
        end
        if (v) begin
            e[0] = r[0] + r[1] + r[2] + r[3];
            e[4] = m[0] + m[1] + m[2] + m[3];
            e[2] = r[0] - r[1] + r[2] - r[3];
            e[6] = m[0] - m[1] + m[2] - m[3];
            e[1] = (r[0] - r[2]) + (m[1] - m[3]);
            e[5] = (m[0] - m[2]) - (r[1] - r[3]);
            e[3] = (r[0] - r[2]) - (m[1] - m[3]);
            e[7] = (m[0] - m[2]) + (r[1] - r[3]);
            q_cyc.push_back(cyc);
            for (int k = 0; k < 8; k++) q_val.push_back(e[k]);
        end
        @(negedge clk);
    endtask

    function automatic int sx(input int v);
        return int'($signed(IN_W'(v)));
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (q_cyc.size() == 0) begin
                    check("R2 unexpected valid", 1, 0);
                end else begin
                    // R2 R9: result appears exactly two edges after its group
                    check("R2 latency", cyc, q_cyc.pop_front() + 2);
                    for (int k = 0; k < 8; k++) begin
                        last_val[k] = q_val.pop_front();
                        check(tag(k), got(k), last_val[k]);
                    end
                    have_last = 1;
                end
            end else if (have_last) begin
                for (int k = 0; k < 8; k++) check("R8 hold", got(k), last_val[k]);
            end else begin
                for (int k = 0; k < 8; k++) check("R1 idle zero", got(k), 0);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int r[4];
        int m[4];
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_re    = '0;
        in_im    = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", int'(out_valid), 0);
        for (int k = 0; k < 8; k++) check("R1 reset zero", got(k), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // impulse at x0
        r = '{1, 0, 0, 0}; m = '{0, 0, 0, 0}; send(1, r, m);
        // idle with junk data (R8)
        r = '{999, -5, 77, 3}; m = '{-1, 2, 3, 4}; send(0, r, m);
        send(0, r, m);
        // real unit at x1: exercises -j rotation (R5, R6)
        r = '{0, 1, 0, 0}; m = '{0, 0, 0, 0}; send(1, r, m);
        // imaginary unit at x3
        r = '{0, 0, 0, 0}; m = '{0, 0, 0, 7}; send(1, r, m);
        // generic mixed pattern
        r = '{100, -200, 300, -400}; m = '{-50, 60, -70, 80}; send(1, r, m);
        send(0, r, m);
        // R7 extremes
        r = '{32767, 32767, 32767, 32767}; m = '{-32768, -32768, -32768, -32768}; send(1, r, m);
        r = '{-32768, 32767, -32768, 32767}; m = '{32767, -32768, -32768, 32767}; send(1, r, m);
        r = '{32767, -32768, -32768, 32767}; m = '{-32768, -32768, 32767, 32767}; send(1, r, m);
        // R9: back-to-back stream
        for (int n = 0; n < 24; n++) begin
            for (int k = 0; k < 4; k++) begin
                r[k] = sx((n * 7919 + k * 4099) ^ (n << 5));
                m[k] = sx((n * 3571 - k * 1237) ^ (k << 9));
            end
            send(1, r, m);
        end
        r = '{1, 2, 3, 4}; m = '{5, 6, 7, 8}; send(0, r, m);
        // mid-stream reset (R1)
        r = '{11, 22, 33, 44}; m = '{1, 1, 1, 1}; send(1, r, m);
        rst_n = 1'b0;
        q_cyc.delete();
        q_val.delete();
        have_last = 0;
        @(negedge clk);
        check("R1 valid in reset", int'(out_valid), 0);
        for (int k = 0; k < 8; k++) check("R1 cleared", got(k), 0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        r = '{-3, 9, -27, 81}; m = '{2, -4, 8, -16}; send(1, r, m);
        send(0, r, m);
        send(0, r, m);
        send(0, r, m);
        done = 1;
        check("R2 queue drained", q_cyc.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule